// File: doc/BRIEF.md
# IEC958 Audio Subframe Formatter

This block sits in front of an HDMI audio engine and turns a stream of 32-bit audio words into the subframe layout that engine consumes. Each output word holds the audio sample in bits 23..0. Above the sample it carries four flag bits: validity, user, channel status and parity. Bit 28 marks the start of a channel-status block.

The block has two modes. In pass-through mode the producer already supplies complete IEC958 subframes, and the block only moves the fields into place. In PCM mode the producer supplies plain 24-bit samples. The block then generates the flag bits itself. It walks through a 192-frame channel-status block for up to eight interleaved channels. The channel-status bit of each frame comes from four configuration bytes, which software loads through a small write port. The hardware fills in a per-channel channel-number field inside those bytes. Input and output are valid/ready streams, with one register stage between them.

Top module: `iec_subframe_fmt`

## Requirements
- R1: With `fmt_pcm` low, an accepted word `d` produces the output word `{3'b000, d[3], d[31:4]}`. The audio and P,C,U,V fields move down by four bits, and input bit 3 (set in the block-start preamble code 8, clear in the even and odd codes 4 and 2) lands in bit 28.
- R2: With `fmt_pcm` high, output bits 23..0 equal input bits 23..0. Output bits 24 (validity) and 25 (user) are 0, bits 31..29 are 0, and input bits 31..24 have no effect.
- R3: In PCM mode, output bit 27 is set so that bits 27..0 of the word together contain an even number of ones. This makes bit 27 the even parity of bits 26..0.
- R4: In PCM mode, output bit 26 is the channel-status bit of the current frame index f. For f below 32 it is bit (f mod 8) of configuration byte f/8, where `cfg_addr` selects the byte. For f of 32 or more it is 0.
- R5: Bits 7..4 of configuration byte 2 are not taken from the register. They are replaced by the current channel index plus 1, so frames 20 to 23 carry that 4-bit number, LSB first.
- R6: In PCM mode, output bit 28 is 1 only for the word at frame 0, channel 0, and 0 for every other word.
- R7: Each accepted word advances the channel index. The channel index wraps after (count-1). On each wrap the frame index advances, and it wraps from 191 to 0. The count is `chan_count` clamped to the range 2..8.
- R8: A restart sets both indices to zero. A restart happens when `flush` is high, when `fmt_pcm` differs from its value in the previous cycle, or when the clamped count differs from its previous value. The word accepted in the restart cycle is treated as frame 0, channel 0.
- R9: `in_ready` equals `out_ready`. When `out_ready` is high, `out_valid` takes the value of `in_valid` one cycle later, and an accepted word appears on `out_data` one cycle after it is accepted. When `out_ready` is low, `out_valid` and `out_data` hold.
- R10: After reset, `out_valid` is 0, both indices are 0, and all four configuration bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_pcm | input | 1 | 1 = PCM mode, 0 = pass-through mode |
| chan_count | input | 4 | Number of interleaved channels (clamped to 2..8) |
| flush | input | 1 | Restart the frame and channel indices |
| cfg_we | input | 1 | Write enable for a channel-status byte |
| cfg_addr | input | 2 | Channel-status byte select |
| cfg_data | input | 8 | Channel-status byte value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 32 | Formatted subframe word |

## Verification
The assertions check the following on every cycle:
- the output holds while stalled, and `out_valid` follows `in_valid`;
- the pass-through bit mapping;
- the fixed-zero fields of a PCM word;
- the even parity of a PCM word;
- the block-start flag that follows a flush.

Only the directed scenarios can show the properties that depend on sequence:
- which channel-status bit belongs to which frame;
- the per-channel number inside byte 2;
- the wrap from 191 back to 0;
- count clamping;
- restarts on a change of mode or count.

For these, the bench runs its own frame and channel model and compares every word.

// File: rtl/iec_fmt_pkg.sv
package iec_fmt_pkg;

    localparam int WORD_W       = 32;
    localparam int AUDIO_W      = 24;
    localparam int MAX_CH       = 8;
    localparam int MIN_CH       = 2;
    localparam int BLOCK_FRAMES = 192;
    localparam int CS_BYTES     = 4;
    localparam int CHNUM_BYTE   = 2;
    localparam int CHNUM_LSB    = 4;
    localparam int CHNUM_W      = 4;

    typedef enum logic {
        FMT_PASS = 1'b0,
        FMT_PCM  = 1'b1
    } fmt_mode_e;

    // Output subframe layout, MSB first.
    typedef struct packed {
        logic [2:0]         spare;
        logic               blk;
        logic               par;
        logic               cs;
        logic               usr;
        logic               vld;
        logic [AUDIO_W-1:0] audio;
    } subframe_t;

    // Pass-through: shift down by four, preamble bit 3 becomes the block flag.
    function automatic subframe_t repack_pass(input logic [WORD_W-1:0] w);
        subframe_t s;
        s = subframe_t'({3'b000, w[3], w[WORD_W-1:4]});
        return s;
    endfunction

    // Even parity: returns 1 when the argument has an odd count of ones.
    function automatic logic even_par(input logic [AUDIO_W+2:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/iec_cs_store.sv
module iec_cs_store #(
    parameter int N_BYTES  = iec_fmt_pkg::CS_BYTES,
    parameter int N_CH_MAX = iec_fmt_pkg::MAX_CH,
    parameter int N_FRAMES = iec_fmt_pkg::BLOCK_FRAMES,
    localparam int AW      = $clog2(N_BYTES),
    localparam int CHW     = $clog2(N_CH_MAX),
    localparam int FW      = $clog2(N_FRAMES),
    localparam int NBITS   = N_BYTES * 8,
    localparam int BW      = $clog2(NBITS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [7:0]     cfg_data,
    input  logic [FW-1:0]  frame,
    input  logic [CHW-1:0] chan,
    output logic           cs_bit
);
    import iec_fmt_pkg::*;

    localparam int CHNUM_POS = CHNUM_BYTE * 8 + CHNUM_LSB;

    logic [7:0]       cs_q [N_BYTES];
    logic [NBITS-1:0] flat;
    logic [NBITS-1:0] bits;
    logic [CHNUM_W-1:0] chnum;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                cs_q[b] <= '0;
            else if (cfg_we && cfg_addr == AW'(b))
                cs_q[b] <= cfg_data;
        end
        assign flat[b*8 +: 8] = cs_q[b];
    end

    // Channel number field is owned by hardware, one value per channel.
    always_comb begin
        chnum = CHNUM_W'(chan) + CHNUM_W'(1);
        bits  = flat;
        bits[CHNUM_POS +: CHNUM_W] = chnum;
    end

    // Frames past the stored bits carry zero.
    always_comb begin
        if (frame < FW'(NBITS))
            cs_bit = bits[frame[BW-1:0]];
        else
            cs_bit = 1'b0;
    end

endmodule

// File: rtl/iec_seq_counter.sv
module iec_seq_counter #(
    parameter int N_CH_MAX = iec_fmt_pkg::MAX_CH,
    parameter int N_FRAMES = iec_fmt_pkg::BLOCK_FRAMES,
    localparam int CNT_W   = $clog2(N_CH_MAX + 1),
    localparam int CH_W    = $clog2(N_CH_MAX),
    localparam int FR_W    = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [CNT_W-1:0] count,
    output logic [FR_W-1:0]  cur_frame,
    output logic [CH_W-1:0]  cur_chan
);
    logic [FR_W-1:0] frame_q, base_f, next_f;
    logic [CH_W-1:0] chan_q, base_c, next_c;
    logic            wrap_c, wrap_f;

    always_comb begin
        base_f = restart ? '0 : frame_q;
        base_c = restart ? '0 : chan_q;
        wrap_c = (CNT_W'(base_c) == count - CNT_W'(1));
        wrap_f = (base_f == FR_W'(N_FRAMES - 1));
        next_f = base_f;
        next_c = base_c;
        if (step) begin
            if (wrap_c) begin
                next_c = '0;
                next_f = wrap_f ? '0 : base_f + FR_W'(1);
            end else begin
                next_c = base_c + CH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            chan_q  <= '0;
        end else begin
            frame_q <= next_f;
            chan_q  <= next_c;
        end
    end

    assign cur_frame = base_f;
    assign cur_chan  = base_c;

endmodule

// File: rtl/iec_word_build.sv
module iec_word_build
    import iec_fmt_pkg::*;
(
    input  fmt_mode_e         mode,
    input  logic [WORD_W-1:0] din,
    input  logic              cs_bit,
    input  logic              blk,
    output subframe_t         word
);
    subframe_t pcm_w;

    always_comb begin
        pcm_w       = '0;
        pcm_w.audio = din[AUDIO_W-1:0];
        pcm_w.vld   = 1'b0;
        pcm_w.usr   = 1'b0;
        pcm_w.cs    = cs_bit;
        pcm_w.blk   = blk;
        pcm_w.par   = even_par({pcm_w.cs, pcm_w.usr, pcm_w.vld, pcm_w.audio});
    end

    always_comb begin
        unique case (mode)
            FMT_PCM:  word = pcm_w;
            default:  word = repack_pass(din);
        endcase
    end

endmodule

// File: rtl/iec_subframe_fmt.sv
module iec_subframe_fmt #(
    parameter int N_CH_MAX = iec_fmt_pkg::MAX_CH,
    parameter int N_CH_MIN = iec_fmt_pkg::MIN_CH,
    parameter int N_FRAMES = iec_fmt_pkg::BLOCK_FRAMES,
    parameter int N_BYTES  = iec_fmt_pkg::CS_BYTES
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            fmt_pcm,
    input  logic [$clog2(N_CH_MAX+1)-1:0]   chan_count,
    input  logic                            flush,
    input  logic                            cfg_we,
    input  logic [$clog2(N_BYTES)-1:0]      cfg_addr,
    input  logic [7:0]                      cfg_data,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [31:0]                     in_data,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [31:0]                     out_data
);
    import iec_fmt_pkg::*;

    localparam int CNT_W = $clog2(N_CH_MAX + 1);
    localparam int CH_W  = $clog2(N_CH_MAX);
    localparam int FR_W  = $clog2(N_FRAMES);

    fmt_mode_e        mode, mode_q;
    logic [CNT_W-1:0] count_eff, count_q;
    logic             accept, restart, blk, cs_bit;
    logic [FR_W-1:0]  cur_frame;
    logic [CH_W-1:0]  cur_chan;
    subframe_t        word;

    assign mode     = fmt_mode_e'(fmt_pcm);
    assign in_ready = out_ready;
    assign accept   = in_valid & out_ready;

    always_comb begin
        if (chan_count < CNT_W'(N_CH_MIN))
            count_eff = CNT_W'(N_CH_MIN);
        else if (chan_count > CNT_W'(N_CH_MAX))
            count_eff = CNT_W'(N_CH_MAX);
        else
            count_eff = chan_count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FMT_PASS;
            count_q <= CNT_W'(N_CH_MIN);
        end else begin
            mode_q  <= mode;
            count_q <= count_eff;
        end
    end

    assign restart = flush || (mode != mode_q) || (count_eff != count_q);

    iec_seq_counter #(
        .N_CH_MAX (N_CH_MAX),
        .N_FRAMES (N_FRAMES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .step      (accept),
        .count     (count_eff),
        .cur_frame (cur_frame),
        .cur_chan  (cur_chan)
    );

    iec_cs_store #(
        .N_BYTES  (N_BYTES),
        .N_CH_MAX (N_CH_MAX),
        .N_FRAMES (N_FRAMES)
    ) u_cs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .frame    (cur_frame),
        .chan     (cur_chan),
        .cs_bit   (cs_bit)
    );

    assign blk = (mode == FMT_PCM) && (cur_frame == '0) && (cur_chan == '0);

    iec_word_build u_build (
        .mode   (mode),
        .din    (in_data),
        .cs_bit (cs_bit),
        .blk    (blk),
        .word   (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (out_ready) begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= word;
        end
    end

endmodule

// File: rtl/iec_subframe_fmt_chk.sv
module iec_subframe_fmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        fmt_pcm,
    input logic        flush,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data
);
    logic acc;
    assign acc = in_valid && out_ready;

    // R9: a stalled output keeps its word
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: valid follows the input when downstream is ready
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_ready |=> (out_valid == $past(in_valid)));

    // R1: pass-through field mapping
    a_r1_pass_layout: assert property (@(posedge clk) disable iff (rst)
        (acc && !fmt_pcm) |=>
            (out_data == {3'b000, $past(in_data[3]), $past(in_data[31:4])}));

    // R2: PCM sample kept, fixed fields zero
    a_r2_pcm_fields: assert property (@(posedge clk) disable iff (rst)
        (acc && fmt_pcm) |=>
            (out_data[23:0] == $past(in_data[23:0]) &&
             out_data[25:24] == 2'b00 && out_data[31:29] == 3'b000));

    // R3: even parity over bits 27..0 of a PCM word
    a_r3_pcm_parity: assert property (@(posedge clk) disable iff (rst)
        (acc && fmt_pcm) |=> (^out_data[27:0] == 1'b0));

    // R8: a flush makes the word accepted with it a block start
    a_r8_flush_block_start: assert property (@(posedge clk) disable iff (rst)
        (acc && fmt_pcm && flush) |=> out_data[28]);

endmodule

bind iec_subframe_fmt iec_subframe_fmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fmt_pcm   (fmt_pcm),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/iec_subframe_fmt_test.sv
`timescale 1ns/1ps
module iec_subframe_fmt_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        fmt_pcm;
    logic [3:0]  chan_count;
    logic        flush;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [7:0]  cfg_data;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;

    always #4 clk = ~clk;

    iec_subframe_fmt uut (
        .clk(clk), .rst(rst), .fmt_pcm(fmt_pcm), .chan_count(chan_count),
        .flush(flush), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // bench model state
    int         m_fr, m_ch, m_n;
    logic [7:0] csb [4];

    task automatic check_eq(input string tag, input logic [32:0] act, input logic [32:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_pcm(input logic [23:0] s, input int f, input int c);
        logic csbit, blk, par;
        if (f < 32) begin
            if (f >= 20 && f < 24) csbit = 1'(((c + 1) >> (f - 20)) & 1);
            else                   csbit = csb[f/8][f%8];
        end else csbit = 1'b0;
        blk = (f == 0 && c == 0);
        par = ^{csbit, s};
        return {3'b000, blk, par, csbit, 2'b00, s};
    endfunction

    task automatic model_step();
        m_ch++;
        if (m_ch == m_n) begin
            m_ch = 0;
            m_fr++;
            if (m_fr == 192) m_fr = 0;
        end
    endtask

    task automatic model_restart();
        m_fr = 0;
        m_ch = 0;
    endtask

    // called at a negedge; returns at the next negedge
    task automatic push(input logic [31:0] d, input logic [31:0] exp, input string tag);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b0;
        check_eq(tag, {out_valid, out_data}, {1'b1, exp});
    endtask

    task automatic push_pcm(input logic [23:0] s, input string tag);
        logic [31:0] e;
        e = model_pcm(s, m_fr, m_ch);
        push({8'hE7, s}, e, tag);
        model_step();
    endtask

    task automatic cfg_write(input int a, input logic [7:0] v);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
        csb[a] = v;
    endtask

    function automatic logic [23:0] samp(input int i);
        return 24'(i * 24'h01_2345) ^ 24'hA5_3C96;
    endfunction

    task automatic t_reset();
        rst = 1'b1; fmt_pcm = 1'b0; chan_count = 4'd2; flush = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        for (int i = 0; i < 4; i++) csb[i] = 8'h00;
        m_n = 2; model_restart();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R10 out_valid after reset", {32'b0, out_valid}, 33'd0);
        check_eq("R9 in_ready follows out_ready", {32'b0, in_ready}, 33'd1);
    endtask

    task automatic t_passthrough();
        logic [31:0] pats [4];
        pats[0] = 32'hA5A5_A5A8; pats[1] = 32'h1234_5674;
        pats[2] = 32'hFFFF_FFF2; pats[3] = 32'h8000_0008;
        fmt_pcm = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push(pats[i], {3'b000, pats[i][3], pats[i][31:4]}, "R1 pass-through");
            model_step();
        end
    endtask

    task automatic t_pcm_zero_cs();
        fmt_pcm = 1'b1; chan_count = 4'd2; m_n = 2;
        @(negedge clk);
        model_restart();
        for (int i = 0; i < 64; i++) push_pcm(samp(i), "R10/R5 zero cs bytes");
    endtask

    task automatic t_pcm_stereo_block();
        cfg_write(0, 8'h5A);
        cfg_write(1, 8'hC3);
        cfg_write(2, 8'hF9);
        cfg_write(3, 8'h81);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_restart();
        for (int i = 0; i < 193 * 2; i++)
            push_pcm(samp(i + 7), "R2/R3/R4/R6/R7 stereo block");
    endtask

    task automatic t_pcm_eight();
        chan_count = 4'd8; m_n = 8;
        @(negedge clk);
        model_restart();
        for (int i = 0; i < 26 * 8; i++) push_pcm(samp(i + 3), "R5/R7 eight channels");
    endtask

    task automatic t_clamp();
        chan_count = 4'd1; m_n = 2;
        @(negedge clk);
        model_restart();
        for (int i = 0; i < 5; i++) push_pcm(samp(i), "R7 count clamp low");
        chan_count = 4'd15; m_n = 8;
        @(negedge clk);
        model_restart();
        for (int i = 0; i < 10; i++) push_pcm(samp(i + 40), "R7 count clamp high");
    endtask

    task automatic t_backpressure();
        logic [31:0] held;
        push_pcm(samp(100), "R9 before stall");
        held = out_data;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = {8'h00, samp(101)};
        repeat (3) @(negedge clk);
        check_eq("R9 held data while stalled", {out_valid, out_data}, {1'b1, held});
        check_eq("R9 in_ready low while stalled", {32'b0, in_ready}, 33'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R9 word after stall", {out_valid, out_data},
                 {1'b1, model_pcm(samp(101), m_fr, m_ch)});
        model_step();
        @(negedge clk);
        check_eq("R9 out_valid drops when idle", {32'b0, out_valid}, 33'd0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) push_pcm(samp(i + 200), "R7 before flush");
        flush = 1'b1;
        model_restart();
        push_pcm(samp(210), "R8 flush with word");
        push_pcm(samp(211), "R8 after flush");
    endtask

    task automatic t_mode_change();
        fmt_pcm = 1'b0;
        push(32'h0F0F_0F04, {3'b000, 1'b0, 28'h0F0F_0F0}, "R1 pass between pcm runs");
        fmt_pcm = 1'b1;
        model_restart();
        push_pcm(samp(300), "R8 mode change restart");
        push_pcm(samp(301), "R8 after mode change");
    endtask

    task automatic t_count_change();
        push_pcm(samp(400), "R7 before count change");
        chan_count = 4'd4; m_n = 4;
        model_restart();
        for (int i = 0; i < 6; i++) push_pcm(samp(401 + i), "R8 count change restart");
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_pcm_zero_cs();
        t_pcm_stereo_block();
        t_pcm_eight();
        t_clamp();
        t_backpressure();
        t_flush();
        t_mode_change();
        t_count_change();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule